// File: doc/BRIEF.md
# Chained Single-Address DMA Channel

This block is one DMA channel that works in single-address mode. Only the memory side of each transfer is addressed. The channel issues a memory word address with a strobe, while the I/O device reads or writes the data bus directly. Each device request starts one transfer unit. A unit is a single 32-bit word, or a four-word burst when the channel is set up for 32-bit transfers on a 32-bit device port. Before a unit starts, the channel requests the bus and waits for a grant.

Software programs the channel through a small register port. There are registers for the control bits, the status flags, the source and destination addresses, the remaining byte count and a next-transfer byte count. A transfer ends normally when the byte count reaches zero. If the continue bit is set at that point, the hardware does the following in one step:
- it loads the memory-side address from the opposite address register;
- it loads the byte count from the next-count register;
- it clears the continue bit, sets a chained-completion flag and can raise an interrupt.

The next transfer then proceeds on further device requests, with no restart by software. A stop command halts the channel at the next unit boundary.

Top module: `dma_chain_channel`

## Requirements
- R1: After reset every register reads 0, and `busReq`, `busStrobe`, `irq` and `doneFlag` are low with `busAddr` at 0. While the channel is not busy, no bus request or strobe is driven.
- R2: In single-word mode each device request produces exactly one strobe. The strobe carries the memory address (source register when control bit 4 is 1, destination register otherwise). Afterwards that address register has risen by 4 and the byte count has fallen by 4. A bus request rises only on a cycle after `devReq` was high.
- R3: Burst mode applies when control bit 3 is 1, size field bits 7:6 are 00 and port field bits 9:8 are 11. A request from an address with low nibble 0x0 produces four consecutive strobes at offsets 0x0, 0x4, 0x8, 0xC. The address then advances by 16, and a strobe run never exceeds four beats.
- R4: A burst from low nibble 0xC strobes offsets 0xC, 0x8, 0x4, 0x0. The address then ends 16 below the start, and consecutive strobes differ by exactly 4.
- R5: With control bit 3 set but the port field not 11, each request moves one word only.
- R6: A burst-mode request from any low nibble other than 0x0 or 0xC drives no bus request. It sets status bit 2 and clears the enable bit (control bit 0).
- R7: When the count reaches zero with continue (control bit 1) clear, the channel sets status bit 0 and drives `doneFlag`. It also clears the enable bit and drops busy (status bit 3 and `chanBusy`).
- R8: When the count reaches zero with continue set and memory as source, the hardware does all of the following, and the next request transfers from the new address:
  - copies the destination register into the source register;
  - copies the next-count register into the count register;
  - clears control bit 1 and sets status bit 1;
  - stays enabled.
- R9: The same event with memory as destination copies the source register into the destination register.
- R10: `irq` equals status bit 1 gated by the continue-interrupt enable (control bit 2). Writing 1 to a status bit clears it.
- R11: Writing control bit 5 as 1 halts the channel at the next unit boundary. The halt clears enable and continue, sets no completion flag, and later requests drive no bus cycle.
- R12: `busReq` stays high while the grant is low, and no strobe occurs before `busGnt` has been sampled high. Strobes only occur while `busReq` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 3 | Register select: 0 control, 1 status, 2 source, 3 destination, 4 count, 5 next count |
| regWdata | input | 32 | Register write data |
| regRdata | output | 32 | Register read data (combinational on regAddr) |
| devReq | input | 1 | Device transfer request |
| busReq | output | 1 | Bus ownership request |
| busGnt | input | 1 | Bus grant |
| busStrobe | output | 1 | Valid memory address cycle |
| busAddr | output | 32 | Memory word address, 0 when no strobe |
| chanBusy | output | 1 | Channel active |
| doneFlag | output | 1 | Normal completion flag |
| irq | output | 1 | Continue interrupt |

## Verification
The results of a device request fall due on fixed cycles, each a set number of clock edges after the one before:

| Result | When it falls due |
|---|---|
| `busReq` | one edge after the edge that samples `devReq` |
| First strobe | one edge after the edge that samples the grant |
| Remaining burst strobes | one per cycle after the first strobe |
| Status, address and count updates | one edge after the last strobe |
| Register writes | visible one edge after the write strobe |

A scoreboard queue holds the expected strobe addresses, and the monitor compares them at the falling edge of every strobe cycle. The register, flag and interrupt checks are read back only after the request handshake has closed and three more cycles have elapsed. By then every update is settled.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  localparam int WORD_BYTES = 4;

  localparam logic [2:0] REG_CTRL = 3'd0;
  localparam logic [2:0] REG_STAT = 3'd1;
  localparam logic [2:0] REG_SRC  = 3'd2;
  localparam logic [2:0] REG_DST  = 3'd3;
  localparam logic [2:0] REG_CNT  = 3'd4;
  localparam logic [2:0] REG_NEXT = 3'd5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_BREQ,
    ST_XFER,
    ST_FIN
  } chanState_t;

  typedef struct packed {
    logic armXfer;
    logic beatStep;
    logic reload;
    logic complete;
    logic alignFault;
    logic halt;
  } dpStrobe_t;

endpackage

// File: rtl/dmac_datapath.sv
module dmac_datapath
  import dmac_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  dpStrobe_t         strb,
  input  logic              busy,
  output logic              enable,
  output logic              burstMode,
  output logic              alignOk,
  output logic              cntZero,
  output logic              contEn,
  output logic              stopPend,
  output logic [ADDR_W-1:0] memAddr,
  output logic              irq,
  output logic              doneFlag
);

  localparam logic [ADDR_W-1:0] ADDR_STEP = ADDR_W'(WORD_BYTES);
  localparam logic [CNT_W-1:0]  CNT_STEP  = CNT_W'(WORD_BYTES);

  logic [ADDR_W-1:0] srcAddr, dstAddr, steppedAddr;
  logic [CNT_W-1:0]  byteCnt, nextCnt;
  logic              enReg, contReg, cieReg, burstReq, memSrc, stopReg, descReg;
  logic [1:0]        xSize, pSize;
  logic              stDone, stNext, stErr;
  logic [3:0]        lowNib;

  assign memAddr     = memSrc ? srcAddr : dstAddr;
  assign lowNib      = memAddr[3:0];
  assign burstMode   = burstReq && (xSize == 2'b00) && (pSize == 2'b11);
  assign alignOk     = (lowNib == 4'h0) || (lowNib == 4'hC);
  assign steppedAddr = descReg ? memAddr - ADDR_STEP : memAddr + ADDR_STEP;
  assign cntZero     = (byteCnt == '0);
  assign enable      = enReg;
  assign contEn      = contReg;
  assign stopPend    = stopReg;
  assign irq         = stNext & cieReg;
  assign doneFlag    = stDone;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcAddr  <= '0;
      dstAddr  <= '0;
      byteCnt  <= '0;
      nextCnt  <= '0;
      enReg    <= 1'b0;
      contReg  <= 1'b0;
      cieReg   <= 1'b0;
      burstReq <= 1'b0;
      memSrc   <= 1'b0;
      stopReg  <= 1'b0;
      descReg  <= 1'b0;
      xSize    <= 2'b00;
      pSize    <= 2'b00;
      stDone   <= 1'b0;
      stNext   <= 1'b0;
      stErr    <= 1'b0;
    end else begin
      if (strb.armXfer) descReg <= burstMode && (lowNib == 4'hC);
      if (strb.beatStep) begin
        if (memSrc) srcAddr <= steppedAddr;
        else        dstAddr <= steppedAddr;
        byteCnt <= byteCnt - CNT_STEP;
      end
      if (strb.reload) begin
        if (memSrc) srcAddr <= dstAddr;
        else        dstAddr <= srcAddr;
        byteCnt <= nextCnt;
        contReg <= 1'b0;
        stNext  <= 1'b1;
      end
      if (strb.complete) begin
        stDone <= 1'b1;
        enReg  <= 1'b0;
      end
      if (strb.alignFault) begin
        stErr <= 1'b1;
        enReg <= 1'b0;
      end
      if (strb.halt) begin
        enReg   <= 1'b0;
        contReg <= 1'b0;
        stopReg <= 1'b0;
      end
      // software writes take precedence over same-cycle hardware updates
      if (regWr) begin
        case (regAddr)
          REG_CTRL: begin
            enReg    <= regWdata[0];
            contReg  <= regWdata[1];
            cieReg   <= regWdata[2];
            burstReq <= regWdata[3];
            memSrc   <= regWdata[4];
            if (regWdata[5]) stopReg <= 1'b1;
            xSize    <= regWdata[7:6];
            pSize    <= regWdata[9:8];
          end
          REG_STAT: begin
            if (regWdata[0]) stDone <= 1'b0;
            if (regWdata[1]) stNext <= 1'b0;
            if (regWdata[2]) stErr  <= 1'b0;
          end
          REG_SRC:  srcAddr <= regWdata[ADDR_W-1:0];
          REG_DST:  dstAddr <= regWdata[ADDR_W-1:0];
          REG_CNT:  byteCnt <= regWdata[CNT_W-1:0];
          REG_NEXT: nextCnt <= regWdata[CNT_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    regRdata = '0;
    case (regAddr)
      REG_CTRL: regRdata = {22'd0, pSize, xSize, 1'b0, memSrc, burstReq, cieReg, contReg, enReg};
      REG_STAT: regRdata = {28'd0, busy, stErr, stNext, stDone};
      REG_SRC:  regRdata = 32'(srcAddr);
      REG_DST:  regRdata = 32'(dstAddr);
      REG_CNT:  regRdata = 32'(byteCnt);
      REG_NEXT: regRdata = 32'(nextCnt);
      default:  regRdata = '0;
    endcase
  end

endmodule

// File: rtl/dmac_control.sv
module dmac_control
  import dmac_pkg::*;
#(
  parameter int BURST_BEATS = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      enable,
  input  logic      burstMode,
  input  logic      alignOk,
  input  logic      cntZero,
  input  logic      contEn,
  input  logic      stopPend,
  input  logic      devReq,
  input  logic      busGnt,
  output dpStrobe_t strb,
  output logic      busReq,
  output logic      busStrobe,
  output logic      busy
);

  localparam int BEAT_W = (BURST_BEATS > 1) ? $clog2(BURST_BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BURST_BEATS - 1);

  chanState_t        state, nextState;
  logic [BEAT_W-1:0] beatCnt;
  logic              burstRun;
  logic              lastBeat;

  assign lastBeat  = burstRun ? (beatCnt == LAST_BEAT) : 1'b1;
  assign busReq    = (state == ST_BREQ) || (state == ST_XFER);
  assign busStrobe = (state == ST_XFER);
  assign busy      = (state != ST_IDLE);

  always_comb begin
    strb      = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (stopPend)    strb.halt = 1'b1;
        else if (enable) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (stopPend || !enable) begin
          strb.halt = 1'b1;
          nextState = ST_IDLE;
        end else if (devReq) begin
          if (burstMode && !alignOk) begin
            strb.alignFault = 1'b1;
            nextState       = ST_IDLE;
          end else begin
            strb.armXfer = 1'b1;
            nextState    = ST_BREQ;
          end
        end
      end
      ST_BREQ: begin
        if (busGnt) nextState = ST_XFER;
      end
      ST_XFER: begin
        strb.beatStep = 1'b1;
        if (lastBeat) nextState = ST_FIN;
      end
      ST_FIN: begin
        if (stopPend) begin
          strb.halt = 1'b1;
          nextState = ST_IDLE;
        end else if (cntZero) begin
          if (contEn) begin
            strb.reload = 1'b1;
            nextState   = ST_WAIT;
          end else begin
            strb.complete = 1'b1;
            nextState     = ST_IDLE;
          end
        end else begin
          nextState = ST_WAIT;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      beatCnt  <= '0;
      burstRun <= 1'b0;
    end else begin
      state <= nextState;
      if (strb.armXfer) begin
        beatCnt  <= '0;
        burstRun <= burstMode;
      end else if (strb.beatStep) begin
        beatCnt <= beatCnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/dma_chain_channel.sv
module dma_chain_channel
  import dmac_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 32,
  parameter int BURST_BEATS = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [2:0]        regAddr,
  input  logic [31:0]       regWdata,
  output logic [31:0]       regRdata,
  input  logic              devReq,
  output logic              busReq,
  input  logic              busGnt,
  output logic              busStrobe,
  output logic [ADDR_W-1:0] busAddr,
  output logic              chanBusy,
  output logic              doneFlag,
  output logic              irq
);

  dpStrobe_t         strb;
  logic              enable, burstMode, alignOk, cntZero, contEn, stopPend;
  logic [ADDR_W-1:0] memAddr;

  dmac_datapath #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .strb(strb), .busy(chanBusy),
    .enable(enable), .burstMode(burstMode), .alignOk(alignOk),
    .cntZero(cntZero), .contEn(contEn), .stopPend(stopPend),
    .memAddr(memAddr), .irq(irq), .doneFlag(doneFlag)
  );

  dmac_control #(.BURST_BEATS(BURST_BEATS)) u_ctl (
    .clk(clk), .rstN(rstN), .enable(enable), .burstMode(burstMode),
    .alignOk(alignOk), .cntZero(cntZero), .contEn(contEn),
    .stopPend(stopPend), .devReq(devReq), .busGnt(busGnt), .strb(strb),
    .busReq(busReq), .busStrobe(busStrobe), .busy(chanBusy)
  );

  assign busAddr = busStrobe ? memAddr : '0;

endmodule

// File: rtl/dmac_checker.sv
module dmac_checker #(
  parameter int ADDR_W      = 32,
  parameter int BURST_BEATS = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              devReq,
  input logic              busReq,
  input logic              busGnt,
  input logic              busStrobe,
  input logic [ADDR_W-1:0] busAddr,
  input logic              chanBusy
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  int runLen;

  always_ff @(posedge clk) begin
    if (!rstN)          runLen <= 0;
    else if (busStrobe) runLen <= runLen + 1;
    else                runLen <= 0;
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    !chanBusy |-> (!busReq && !busStrobe && busAddr == '0));

  p_req_after_device_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busReq) |-> $past(devReq));

  p_burst_len_r3: assert property (@(posedge clk) disable iff (!rstN)
    runLen <= BURST_BEATS);

  p_word_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busStrobe && $past(busStrobe)) |->
      ((busAddr == $past(busAddr) + STEP) || (busAddr == $past(busAddr) - STEP)));

  p_strobe_in_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    busStrobe |-> busReq);

  p_grant_first_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busStrobe) |-> $past(busGnt));

endmodule

bind dma_chain_channel dmac_checker #(.ADDR_W(ADDR_W), .BURST_BEATS(BURST_BEATS)) u_chk (
  .clk(clk), .rstN(rstN), .devReq(devReq), .busReq(busReq), .busGnt(busGnt),
  .busStrobe(busStrobe), .busAddr(busAddr), .chanBusy(chanBusy)
);

// File: tb/test_dma_chain_channel.sv
module test_dma_chain_channel;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWr = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWdata = 32'd0;
  logic [31:0] regRdata;
  logic        devReq = 1'b0;
  logic        busReq;
  logic        busGnt = 1'b1;
  logic        busStrobe;
  logic [31:0] busAddr;
  logic        chanBusy;
  logic        doneFlag;
  logic        irq;

  int vecs = 0;
  int miss = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];

  always #10 clk = ~clk;

  dma_chain_channel i_dma_chain_channel (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .devReq(devReq),
    .busReq(busReq), .busGnt(busGnt), .busStrobe(busStrobe),
    .busAddr(busAddr), .chanBusy(chanBusy), .doneFlag(doneFlag), .irq(irq)
  );

  task automatic checkEq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      miss++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdChk(input logic [2:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    regAddr = a;
    #1;
    checkEq(tag, regRdata, exp);
  endtask

  // driver side of the scoreboard
  task automatic pushRun(input logic [31:0] start, input int n, input bit desc, input string tag);
    for (int i = 0; i < n; i++) begin
      expQ.push_back(desc ? start - 32'(4 * i) : start + 32'(4 * i));
      tagQ.push_back(tag);
    end
  endtask

  task automatic request();
    @(negedge clk);
    devReq = 1'b1;
    while (!busReq) @(negedge clk);
    devReq = 1'b0;
    while (busReq) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic refusedReq(input string tag);
    logic seen;
    seen = 1'b0;
    @(negedge clk);
    devReq = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      seen = seen | busReq;
    end
    devReq = 1'b0;
    checkEq(tag, {31'd0, seen}, 32'd0);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN && busStrobe) begin
      if (expQ.size() == 0) begin
        vecs++;
        miss++;
        $display("FAIL R2 unexpected strobe actual=%h expected=none", busAddr);
      end else begin
        logic [31:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkEq(t, busAddr, e);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    vecs++;
    miss++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    rdChk(3'd0, 32'h0, "R1 ctrl");
    rdChk(3'd1, 32'h0, "R1 status");
    rdChk(3'd2, 32'h0, "R1 src");
    rdChk(3'd4, 32'h0, "R1 count");
    checkEq("R1 outputs", {28'd0, busReq, busStrobe, irq, doneFlag}, 32'h0);
    checkEq("R1 busAddr", busAddr, 32'h0);

    // R2 / R7: single-word transfers from memory
    wr(3'd2, 32'h0000_1000);
    wr(3'd4, 32'd8);
    wr(3'd0, 32'h11);
    pushRun(32'h1000, 1, 1'b0, "R2 single beat");
    request();
    rdChk(3'd2, 32'h1004, "R2 src stepped");
    rdChk(3'd4, 32'd4, "R2 count stepped");
    pushRun(32'h1004, 1, 1'b0, "R2 single beat");
    request();
    rdChk(3'd1, 32'h1, "R7 done status");
    checkEq("R7 doneFlag", {31'd0, doneFlag}, 32'd1);
    rdChk(3'd0, 32'h10, "R7 enable cleared");
    checkEq("R7 not busy", {31'd0, chanBusy}, 32'd0);
    wr(3'd1, 32'h7);

    // R3: ascending burst
    wr(3'd2, 32'h0000_2000);
    wr(3'd4, 32'd32);
    wr(3'd0, 32'h319);
    pushRun(32'h2000, 4, 1'b0, "R3 ascending burst");
    request();
    pushRun(32'h2010, 4, 1'b0, "R3 ascending burst");
    request();
    rdChk(3'd2, 32'h2020, "R3 src after bursts");
    rdChk(3'd1, 32'h1, "R3 done status");
    wr(3'd1, 32'h7);

    // R4: descending burst, memory as destination
    wr(3'd3, 32'h0000_300C);
    wr(3'd4, 32'd16);
    wr(3'd0, 32'h309);
    pushRun(32'h300C, 4, 1'b1, "R4 descending burst");
    request();
    rdChk(3'd3, 32'h2FFC, "R4 dst after burst");
    rdChk(3'd1, 32'h1, "R4 done status");
    wr(3'd1, 32'h7);

    // R5: burst bit set but port field not 32-bit
    wr(3'd3, 32'h0000_4000);
    wr(3'd4, 32'd8);
    wr(3'd0, 32'h209);
    pushRun(32'h4000, 1, 1'b0, "R5 single beat");
    request();
    rdChk(3'd4, 32'd4, "R5 count after one word");
    pushRun(32'h4004, 1, 1'b0, "R5 single beat");
    request();
    wr(3'd1, 32'h7);

    // R6: illegal burst start offset
    wr(3'd2, 32'h0000_5004);
    wr(3'd4, 32'd16);
    wr(3'd0, 32'h319);
    refusedReq("R6 no bus request");
    rdChk(3'd1, 32'h4, "R6 error status");
    rdChk(3'd0, 32'h318, "R6 enable cleared");
    wr(3'd1, 32'h7);

    // R8 / R10: continue mode, memory as source
    wr(3'd2, 32'h0000_6000);
    wr(3'd3, 32'h0000_7000);
    wr(3'd4, 32'd4);
    wr(3'd5, 32'd8);
    wr(3'd0, 32'h17);
    pushRun(32'h6000, 1, 1'b0, "R8 first transfer");
    request();
    rdChk(3'd1, 32'hA, "R8 chained status busy");
    rdChk(3'd2, 32'h7000, "R8 src reloaded");
    rdChk(3'd4, 32'd8, "R8 count reloaded");
    rdChk(3'd0, 32'h15, "R8 continue cleared");
    checkEq("R10 irq raised", {31'd0, irq}, 32'd1);
    wr(3'd1, 32'h2);
    checkEq("R10 irq cleared", {31'd0, irq}, 32'd0);
    pushRun(32'h7000, 1, 1'b0, "R8 chained transfer");
    request();
    pushRun(32'h7004, 1, 1'b0, "R8 chained transfer");
    request();
    rdChk(3'd1, 32'h1, "R8 final done");
    wr(3'd1, 32'h7);

    // R9: continue mode, memory as destination
    wr(3'd2, 32'h0000_8000);
    wr(3'd3, 32'h0000_9000);
    wr(3'd4, 32'd4);
    wr(3'd5, 32'd4);
    wr(3'd0, 32'h07);
    pushRun(32'h9000, 1, 1'b0, "R9 first transfer");
    request();
    rdChk(3'd3, 32'h8000, "R9 dst reloaded");
    rdChk(3'd0, 32'h05, "R9 continue cleared");
    wr(3'd1, 32'h7);

    // R11: stop while waiting for a request
    wr(3'd0, 32'h25);
    repeat (3) @(negedge clk);
    rdChk(3'd0, 32'h04, "R11 enable cleared by stop");
    refusedReq("R11 no bus request after stop");
    rdChk(3'd1, 32'h0, "R11 no completion flag");
    checkEq("R11 not busy", {31'd0, chanBusy}, 32'd0);

    // R12: grant withheld
    wr(3'd2, 32'h0000_A000);
    wr(3'd4, 32'd4);
    wr(3'd0, 32'h11);
    busGnt = 1'b0;
    @(negedge clk);
    devReq = 1'b1;
    repeat (4) @(negedge clk);
    devReq = 1'b0;
    checkEq("R12 request held", {31'd0, busReq}, 32'd1);
    checkEq("R12 no strobe without grant", {31'd0, busStrobe}, 32'd0);
    pushRun(32'hA000, 1, 1'b0, "R12 strobe after grant");
    busGnt = 1'b1;
    while (busReq) @(negedge clk);
    repeat (3) @(negedge clk);
    rdChk(3'd1, 32'h1, "R12 done after grant");

    checkEq("R2 scoreboard drained", 32'(expQ.size()), 32'd0);
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  end

endmodule